// File: doc/BRIEF.md
# Register Access Guard

This block sits between the CPU request port and a bank of 32-bit memory-mapped control registers. The bank is repeated for two controller instances. Each request gives an address, a read/write flag, byte enables, a burst flag and a master ID. The block sorts the request into one class and acts on it. A legal request goes to the register file as a one-cycle read or write strobe. An illegal request gets that class's own reaction, and the sticky status word records it.

The byte address has three parts. The top four bits hold an instance digit: 2 selects instance 0 and 3 selects instance 1. Bits [7:2] hold the word index. The bits between them must be zero. Word indices 0 to 15 are read/write registers, 16 to 23 are read-only registers, and 40 is the shared status word. Any other index is reserved.

The status word has two sticky bits. Bit 0 records a burst violation and bit 1 records a bus error. Software clears a bit by writing 1 to it. The non-maskable interrupt output follows bit 0. Every request gets a response exactly one cycle later, whatever its class.

Top module: `reg_access_guard`

## Requirements
- R1: Each cycle with `reqValid` high produces `respValid` high in the next cycle. A cycle without a request produces no response in the next cycle.
- R2: A legal read forwards to the register file. A legal read is a CPU request (master ID 0), not a burst, with byte enables 4'hF, address bits [1:0] zero and instance digit 2 or 3, to a read/write or read-only index. It raises `regRdEn` in the same cycle, with `regIdx` equal to the word index and `regInst` equal to digit minus 2. The response carries `regRdata` with `respDataErr` low.
- R3: A legal write to a read/write index raises `regWrEn` in the same cycle and passes the write data through. The response has `respDataErr` low.
- R4: A write to a read-only index (16 to 23) is dropped without error. `regWrEn` stays low, `respDataErr` is low and the status word is unchanged.
- R5: A read to a reserved location sets status bit 1. A reserved location is an unlisted index, an instance digit other than 2 or 3, or nonzero bits between the digit and the index. The response has `respDataErr` high and `respRdata` equal to 32'hDEAD0BAD.
- R6: A write to a reserved location sets status bit 1. It raises no `regWrEn`, and its response has `respDataErr` high.
- R7: A CPU access with byte enables other than 4'hF, or with address bits [1:0] nonzero, is handled like a reserved access. Status bit 1 is set, nothing is forwarded, and the response carries the error flag.
- R8: A CPU request with `reqBurst` high is never forwarded. It sets status bit 0 and gets an error response, and `nmi` is high from the next cycle.
- R9: A request from any master ID other than 0 is refused. Nothing is forwarded, the response carries the error flag and dummy data, and the status word is unchanged even if the request is a burst.
- R10: The status word at index 40 reads as {30'b0, busErr, burstErr} under either instance digit. A written 1 clears a bit and a written 0 leaves it unchanged. Without such a write, a set bit stays set.
- R11: `nmi` is a level equal to status bit 0. It stays high until software clears that bit.
- R12: When several violations coincide, they are resolved in a fixed order: refused master first, then burst, then size or alignment, then reserved location, then read-only drop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 16 | Byte address |
| reqByteEn | input | 4 | Byte enables |
| reqBurst | input | 1 | Request is part of a burst |
| reqMaster | input | 2 | Requesting master ID |
| reqWdata | input | 32 | Write data |
| respValid | output | 1 | Response present |
| respDataErr | output | 1 | Response data-error flag |
| respRdata | output | 32 | Response read data |
| regRdEn | output | 1 | Register file read strobe |
| regWrEn | output | 1 | Register file write strobe |
| regIdx | output | 6 | Register word index |
| regInst | output | 1 | Controller instance select |
| regWdata | output | 32 | Register file write data |
| regRdata | input | 32 | Register file read data |
| nmi | output | 1 | Non-maskable interrupt level |

## Verification
The bench drives requests where violations overlap, such as a burst from a refused master or a partial write to a read-only index. A design with the wrong priority would set the wrong status bit or raise `nmi`. It writes a read-only register and then reads the status word, which catches a design that forwards the write or flags it as an error. It clears the status bits with mixed 1 and 0 patterns, so a design with level clears or full-word clears leaves the wrong bits set. It also reads under an unknown instance digit and with nonzero pad bits, which a design with partial decoding would wrongly forward.

// File: rtl/rag_pkg.sv
package rag_pkg;
  localparam int DATA_W = 32;
  localparam int STS_W  = 2;
  localparam int STS_BURST = 0;
  localparam int STS_BUS   = 1;

  typedef enum logic [2:0] {
    ACC_REFUSED,
    ACC_BURST,
    ACC_BADSIZE,
    ACC_RESERVED,
    ACC_STATUS,
    ACC_READONLY,
    ACC_NORMAL
  } accKindT;

  typedef struct packed {
    logic respFire;
    logic respErr;
    logic fwdRead;
    logic fwdWrite;
    logic setBurst;
    logic setBus;
    logic stsRead;
    logic stsWrite;
  } ctrlStrobeT;
endpackage

// File: rtl/rag_ctrl.sv
module rag_ctrl
  import rag_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int IDX_W      = 6,
  parameter int MASTER_W   = 2,
  parameter int CPU_ID     = 0,
  parameter int NUM_INST   = 2,
  parameter int INST_BASE  = 2,
  parameter int NUM_RW     = 16,
  parameter int NUM_RO     = 8,
  parameter int STATUS_IDX = 40,
  parameter int INST_W     = 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic                reqWrite,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [3:0]          reqByteEn,
  input  logic                reqBurst,
  input  logic [MASTER_W-1:0] reqMaster,
  output ctrlStrobeT          strobes,
  output logic [IDX_W-1:0]    regIdx,
  output logic [INST_W-1:0]   regInst
);
  localparam int NUM_WORDS = 1 << IDX_W;
  localparam int DIGIT_W   = 4;
  localparam int PAD_LO    = IDX_W + 2;
  localparam int PAD_HI    = ADDR_W - DIGIT_W - 1;

  logic [NUM_WORDS-1:0] rwMap, roMap;
  logic [NUM_INST-1:0]  instHitVec;
  logic [DIGIT_W-1:0]   digit;
  logic [IDX_W-1:0]     idx;
  logic                 isCpu, fullWord, padZero, instHit;
  accKindT              kind;

  genvar g;
  generate
    for (g = 0; g < NUM_WORDS; g++) begin : gMap
      assign rwMap[g] = (g < NUM_RW);
      assign roMap[g] = (g >= NUM_RW) && (g < NUM_RW + NUM_RO);
    end
    for (g = 0; g < NUM_INST; g++) begin : gInst
      assign instHitVec[g] = (digit == DIGIT_W'(INST_BASE + g));
    end
  endgenerate

  assign digit    = reqAddr[ADDR_W-1 -: DIGIT_W];
  assign idx      = reqAddr[IDX_W+1:2];
  assign padZero  = (reqAddr[PAD_HI:PAD_LO] == '0);
  assign isCpu    = (reqMaster == MASTER_W'(CPU_ID));
  assign fullWord = (reqByteEn == 4'hF) && (reqAddr[1:0] == 2'b00);
  assign instHit  = |instHitVec;

  always_comb begin
    regInst = '0;
    for (int i = 0; i < NUM_INST; i++)
      if (instHitVec[i]) regInst = INST_W'(i);
  end

  // fixed priority of violation classes
  always_comb begin
    if (!isCpu)                          kind = ACC_REFUSED;
    else if (reqBurst)                   kind = ACC_BURST;
    else if (!fullWord)                  kind = ACC_BADSIZE;
    else if (!instHit || !padZero)       kind = ACC_RESERVED;
    else if (idx == IDX_W'(STATUS_IDX))  kind = ACC_STATUS;
    else if (roMap[idx])                 kind = ACC_READONLY;
    else if (rwMap[idx])                 kind = ACC_NORMAL;
    else                                 kind = ACC_RESERVED;
  end

  always_comb begin
    strobes          = '0;
    strobes.respFire = reqValid;
    if (reqValid) begin
      strobes.respErr  = (kind == ACC_REFUSED) || (kind == ACC_BURST) ||
                         (kind == ACC_BADSIZE) || (kind == ACC_RESERVED);
      strobes.fwdRead  = !reqWrite && ((kind == ACC_NORMAL) || (kind == ACC_READONLY));
      strobes.fwdWrite = reqWrite && (kind == ACC_NORMAL);
      strobes.setBurst = (kind == ACC_BURST);
      strobes.setBus   = (kind == ACC_BADSIZE) || (kind == ACC_RESERVED);
      strobes.stsRead  = !reqWrite && (kind == ACC_STATUS);
      strobes.stsWrite = reqWrite && (kind == ACC_STATUS);
    end
  end

  assign regIdx = idx;

  // R4: the write strobe never reaches a read-only word
  assert_ro_never_written_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.fwdWrite |-> !roMap[regIdx]);
  // R6: forwarded accesses carry no error flag
  assert_fwd_no_err_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.fwdWrite || strobes.fwdRead) |-> !strobes.respErr);
endmodule

// File: rtl/rag_datapath.sv
module rag_datapath
  import rag_pkg::*;
#(
  parameter logic [DATA_W-1:0] DUMMY_DATA = 32'hDEAD0BAD
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        strobes,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] regRdata,
  output logic              regRdEn,
  output logic              regWrEn,
  output logic [DATA_W-1:0] regWdata,
  output logic              respValid,
  output logic              respDataErr,
  output logic [DATA_W-1:0] respRdata,
  output logic [STS_W-1:0]  stsQ,
  output logic              nmi
);
  logic [STS_W-1:0]  stsNext;
  logic [DATA_W-1:0] respNext;

  always_comb begin
    stsNext = stsQ;
    if (strobes.stsWrite) stsNext = stsQ & ~reqWdata[STS_W-1:0];
    if (strobes.setBurst) stsNext[STS_BURST] = 1'b1;
    if (strobes.setBus)   stsNext[STS_BUS]   = 1'b1;
  end

  always_comb begin
    if (strobes.respErr)      respNext = DUMMY_DATA;
    else if (strobes.stsRead) respNext = {{(DATA_W-STS_W){1'b0}}, stsQ};
    else if (strobes.fwdRead) respNext = regRdata;
    else                      respNext = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stsQ        <= '0;
      respValid   <= 1'b0;
      respDataErr <= 1'b0;
      respRdata   <= '0;
    end else begin
      stsQ        <= stsNext;
      respValid   <= strobes.respFire;
      respDataErr <= strobes.respErr;
      respRdata   <= respNext;
    end
  end

  assign regRdEn  = strobes.fwdRead;
  assign regWrEn  = strobes.fwdWrite;
  assign regWdata = reqWdata;
  assign nmi      = stsQ[STS_BURST];

  // R10: a set bit only falls after a clearing write of 1
  assert_sticky_burst_R10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(stsQ[STS_BURST]) |-> $past(strobes.stsWrite && reqWdata[STS_BURST]));
  assert_sticky_bus_R10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(stsQ[STS_BUS]) |-> $past(strobes.stsWrite && reqWdata[STS_BUS]));
endmodule

// File: rtl/reg_access_guard.sv
module reg_access_guard
  import rag_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int IDX_W      = 6,
  parameter int MASTER_W   = 2,
  parameter int CPU_ID     = 0,
  parameter int NUM_RW     = 16,
  parameter int NUM_RO     = 8,
  parameter int STATUS_IDX = 40,
  parameter logic [31:0] DUMMY_DATA = 32'hDEAD0BAD
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic                reqWrite,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [3:0]          reqByteEn,
  input  logic                reqBurst,
  input  logic [MASTER_W-1:0] reqMaster,
  input  logic [31:0]         reqWdata,
  output logic                respValid,
  output logic                respDataErr,
  output logic [31:0]         respRdata,
  output logic                regRdEn,
  output logic                regWrEn,
  output logic [IDX_W-1:0]    regIdx,
  output logic                regInst,
  output logic [31:0]         regWdata,
  input  logic [31:0]         regRdata,
  output logic                nmi
);
  ctrlStrobeT       strobes;
  logic [STS_W-1:0] stsQ;

  rag_ctrl #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .MASTER_W(MASTER_W), .CPU_ID(CPU_ID),
    .NUM_INST(2), .INST_BASE(2), .NUM_RW(NUM_RW), .NUM_RO(NUM_RO),
    .STATUS_IDX(STATUS_IDX), .INST_W(1)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqByteEn(reqByteEn), .reqBurst(reqBurst),
    .reqMaster(reqMaster), .strobes(strobes), .regIdx(regIdx), .regInst(regInst)
  );

  rag_datapath #(.DUMMY_DATA(DUMMY_DATA)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .reqWdata(reqWdata),
    .regRdata(regRdata), .regRdEn(regRdEn), .regWrEn(regWrEn),
    .regWdata(regWdata), .respValid(respValid), .respDataErr(respDataErr),
    .respRdata(respRdata), .stsQ(stsQ), .nmi(nmi)
  );

  assert_resp_follows_R1: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> respValid);
  assert_no_spurious_R1: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !respValid);
  assert_burst_nmi_R8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqMaster == MASTER_W'(CPU_ID) && reqBurst) |=> (nmi && respDataErr));
  assert_refused_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqMaster != MASTER_W'(CPU_ID)) |-> (!regWrEn && !regRdEn));
  assert_refused_sts_R9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqMaster != MASTER_W'(CPU_ID)) |=> ($stable(stsQ) && respDataErr));
  assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({regRdEn, regWrEn}));
endmodule

// File: tb/tb_reg_access_guard.sv
module tb_reg_access_guard;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] DUMMY = 32'hDEAD0BAD;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 0, reqWrite = 0, reqBurst = 0;
  logic [15:0] reqAddr = '0;
  logic [3:0]  reqByteEn = 4'hF;
  logic [1:0]  reqMaster = '0;
  logic [31:0] reqWdata = '0;
  logic respValid, respDataErr, regRdEn, regWrEn, regInst, nmi;
  logic [31:0] respRdata, regWdata, regRdata;
  logic [5:0]  regIdx;

  int nChecks = 0, nFails = 0;
  int expSts = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign regRdata = 32'h5A00_0000 | (32'(regInst) << 16) | 32'(regIdx);

  reg_access_guard dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqByteEn(reqByteEn), .reqBurst(reqBurst),
    .reqMaster(reqMaster), .reqWdata(reqWdata), .respValid(respValid),
    .respDataErr(respDataErr), .respRdata(respRdata), .regRdEn(regRdEn),
    .regWrEn(regWrEn), .regIdx(regIdx), .regInst(regInst), .regWdata(regWdata),
    .regRdata(regRdata), .nmi(nmi)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference: one access, checked at its request and response cycles
  task automatic access(string tag, bit wr, logic [15:0] addr, logic [3:0] be,
                        bit burst, logic [1:0] master, logic [31:0] wdata);
    int digit, idx, pad;
    bit err, fwdR, fwdW, stsR, stsW, legal;
    logic [31:0] expData;
    digit = int'(addr[15:12]); idx = int'(addr[7:2]); pad = int'(addr[11:8]);
    legal = (digit == 2 || digit == 3) && pad == 0;
    err = 0; fwdR = 0; fwdW = 0; stsR = 0; stsW = 0; expData = 0;
    if (master != 0) err = 1;
    else if (burst) begin err = 1; expSts |= 1; end
    else if (be != 4'hF || addr[1:0] != 0) begin err = 1; expSts |= 2; end
    else if (!legal) begin err = 1; expSts |= 2; end
    else if (idx == 40) begin stsR = !wr; stsW = wr; end
    else if (idx < 24) begin fwdR = !wr; fwdW = wr && idx < 16; end
    else begin err = 1; expSts |= 2; end
    if (err) expData = DUMMY;
    else if (stsR) expData = 32'(expSts);
    else if (fwdR) expData = 32'h5A00_0000 | (32'(digit - 2) << 16) | 32'(idx);
    reqValid = 1; reqWrite = wr; reqAddr = addr; reqByteEn = be;
    reqBurst = burst; reqMaster = master; reqWdata = wdata;
    #1;
    check({tag, " regRdEn"}, 32'(regRdEn), 32'(fwdR));
    check({tag, " regWrEn"}, 32'(regWrEn), 32'(fwdW));
    if (fwdR || fwdW) begin
      check({tag, " regIdx"}, 32'(regIdx), 32'(idx));
      check({tag, " regInst"}, 32'(regInst), 32'(digit - 2));
    end
    if (fwdW) check({tag, " regWdata"}, regWdata, wdata);
    if (stsW) expSts &= ~int'(wdata[1:0]);
    @(negedge clk);
    reqValid = 0;
    check({tag, " respValid R1"}, 32'(respValid), 32'd1);
    check({tag, " respDataErr"}, 32'(respDataErr), 32'(err));
    if (!wr || err) check({tag, " respRdata"}, respRdata, expData);
    check({tag, " nmi R11"}, 32'(nmi), 32'(expSts & 1));
  endtask

  task automatic readSts(string tag);
    access({tag, " status R10"}, 0, 16'h20A0, 4'hF, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("reset respValid R1", 32'(respValid), 0);
    check("reset nmi R11", 32'(nmi), 0);
    readSts("R10 reset");
    @(negedge clk);
    check("idle R1", 32'(respValid), 0);

    access("R2 rd rw inst2", 0, 16'h200C, 4'hF, 0, 0, 0);
    access("R2 rd ro inst3", 0, 16'h3050, 4'hF, 0, 0, 0);
    access("R3 wr rw", 1, 16'h3014, 4'hF, 0, 0, 32'hCAFE_1234);
    access("R4 wr ro", 1, 16'h2048, 4'hF, 0, 0, 32'h1111_2222);
    readSts("R4 after ro");
    access("R5 rd rsv idx", 0, 16'h2078, 4'hF, 0, 0, 0);
    readSts("R5");
    access("R10 clear bus", 1, 16'h30A0, 4'hF, 0, 0, 32'h2);
    readSts("R10 cleared");
    access("R5 rd bad digit", 0, 16'h5004, 4'hF, 0, 0, 0);
    access("R5 rd pad nonzero", 0, 16'h2104, 4'hF, 0, 0, 0);
    access("R6 wr rsv", 1, 16'h20C8, 4'hF, 0, 0, 32'h9);
    access("R7 partial wr", 1, 16'h2004, 4'h3, 0, 0, 32'h7);
    access("R7 misaligned rd", 0, 16'h2006, 4'hF, 0, 0, 0);
    access("R12 partial ro", 1, 16'h2044, 4'h1, 0, 0, 32'h7);
    access("R10 keep with 0", 1, 16'h20A0, 4'hF, 0, 0, 32'h0);
    readSts("R10 kept");
    access("R9 refused rd", 0, 16'h200C, 4'hF, 0, 1, 0);
    access("R9 refused burst R12", 1, 16'h2004, 4'hF, 1, 2, 32'h5);
    readSts("R9 sts same");
    access("R8 burst wr", 1, 16'h2004, 4'hF, 1, 0, 32'h5);
    access("R12 burst rsv", 0, 16'h20C8, 4'h1, 1, 0, 0);
    access("R11 clear bus only", 1, 16'h20A0, 4'hF, 0, 0, 32'h2);
    readSts("R11 nmi held");
    access("R11 clear burst", 1, 16'h30A0, 4'hF, 0, 0, 32'h1);
    readSts("R11 final");
    @(negedge clk);
    check("R1 idle end", 32'(respValid), 0);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog R1 actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule